// File: doc/BRIEF.md
# Partition Memory Region Guard

This block decides, for every physical memory access, whether the access may proceed. The space is flat: there is no translation, only address ranges. Each time partition owns a table of up to eight regions. Each region has an inclusive lower and upper bound and four attribute bits. The attributes are an enable, a code/data marker, a read grant and a write grant. The guard compares the access against the table of the partition that is currently running. It drives a combinational allow signal. Each denied access is recorded in registers: a fault flag, the address and the access kind.

The tables of all partitions are held inside the block, so switching partitions is a one-cycle selection of another stored table. Region entries can be written only under trusted privilege, and only a trusted request can change the active partition. An untrusted attempt at either leaves the state alone and raises a one-cycle reject flag. A trusted access skips every check, so the kernel reaches any address.

Top module: `mem_region_guard`

## Requirements
- R1: After reset, fault_o and cfg_reject are 0, active_part is 0, and every region of every partition is disabled. An untrusted access is therefore denied.
- R2: A region matches an address when lo <= address <= hi. Both ends are inclusive, so the bounds themselves are inside and lo-1 and hi+1 are outside.
- R3: Access is denied by default. An untrusted access that matches no enabled region is denied. A region whose enable bit (attribute bit 0) is 0 never matches.
- R4: An instruction fetch (acc_kind 0) is allowed only through a matching region with the code bit set (attribute bit 1).
- R5: A data read (acc_kind 1) needs the read bit (attribute bit 2). A data write (acc_kind 2) needs the write bit (attribute bit 3) and a region whose code bit is 0, so code regions are never writable.
- R6: When several enabled regions match, the access is allowed if any one of them permits it.
- R7: An access with acc_trusted = 1 is always allowed, whatever the tables hold.
- R8: A region write (cfg_we) or a partition load (part_load) with ctl_trusted = 0 has no effect on the tables or on active_part. One cycle later cfg_reject is 1 for one cycle. Trusted requests never raise cfg_reject.
- R9: Only the table of active_part applies. A trusted part_load makes part_sel active from the next cycle, and regions of other partitions then have no effect.
- R10: One cycle after a valid access is denied, fault_o is 1, fault_addr holds its address and fault_kind its kind. fault_o is 0 in the cycle after any allowed or idle cycle.
- R11: The reserved kind (acc_kind 3) is always denied for untrusted accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_trusted | input | 1 | Privilege of the configuration and partition-load requests |
| cfg_we | input | 1 | Write one region entry |
| cfg_part | input | log2(NUM_PART) | Partition whose table is written |
| cfg_idx | input | log2(NUM_REG) | Region slot written |
| cfg_lo | input | ADDR_W | Inclusive lower bound |
| cfg_hi | input | ADDR_W | Inclusive upper bound |
| cfg_attr | input | 4 | {write, read, code, enable} |
| part_load | input | 1 | Request to change the active partition |
| part_sel | input | log2(NUM_PART) | Partition made active |
| active_part | output | log2(NUM_PART) | Partition whose table applies |
| cfg_reject | output | 1 | Pulse: previous request refused as untrusted |
| acc_valid | input | 1 | An access is presented |
| acc_trusted | input | 1 | Access made in trusted mode |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved |
| acc_addr | input | ADDR_W | Physical address |
| acc_allow | output | 1 | Access permitted (combinational) |
| fault_o | output | 1 | Registered: previous access denied |
| fault_addr | output | ADDR_W | Address of the last denied access |
| fault_kind | output | 2 | Kind of the last denied access |

## Verification
The assertions assume that the access inputs are steady for the whole cycle in which acc_valid is high, and that the reset is held long enough to clear the tables. They also assume that cfg_part and part_sel name partitions that exist. The bench drives every input just after a rising edge, so each is stable across the following edge. It only uses partition numbers below NUM_PART. It keeps reset low for several cycles before any request.

// File: rtl/mem_region_guard_pkg.sv
// Shared types for the partition memory region guard.
// Assumes attribute bit 0 is the enable and the access kind is a 2-bit code.
package mem_region_guard_pkg;

    typedef struct packed {
        logic wr;    // bit 3: data writes granted
        logic rd;    // bit 2: data reads granted
        logic code;  // bit 1: region holds instructions
        logic en;    // bit 0: region takes part in matching
    } region_attr_t;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_t;

    localparam int ATTR_W = $bits(region_attr_t);

endpackage

// File: rtl/mrg_table_store.sv
// Region tables of all partitions plus the active-partition register.
// Writes and partition loads take effect only with trusted privilege; an
// untrusted request is dropped and flagged one cycle later.
// Assumes cfg_part and part_sel address existing partitions (others are ignored).
module mrg_table_store
    import mem_region_guard_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_PART = 4,
    parameter int NUM_REG  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_trusted,
    input  logic                          cfg_we,
    input  logic [$clog2(NUM_PART)-1:0]   cfg_part,
    input  logic [$clog2(NUM_REG)-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]             cfg_lo,
    input  logic [ADDR_W-1:0]             cfg_hi,
    input  logic [ATTR_W-1:0]             cfg_attr,
    input  logic                          part_load,
    input  logic [$clog2(NUM_PART)-1:0]   part_sel,
    output logic [$clog2(NUM_PART)-1:0]   active_part,
    output logic                          cfg_reject,
    output logic [NUM_REG-1:0][ADDR_W-1:0] act_lo,
    output logic [NUM_REG-1:0][ADDR_W-1:0] act_hi,
    output logic [NUM_REG-1:0][ATTR_W-1:0] act_attr
);

    logic [ADDR_W-1:0] lo_mem   [NUM_PART][NUM_REG];
    logic [ADDR_W-1:0] hi_mem   [NUM_PART][NUM_REG];
    logic [ATTR_W-1:0] attr_mem [NUM_PART][NUM_REG];

    logic wr_ok;
    logic ld_ok;

    // Qualify requests by privilege and by a valid partition number.
    assign wr_ok = cfg_we && ctl_trusted && (int'(cfg_part) < NUM_PART);
    assign ld_ok = part_load && ctl_trusted && (int'(part_sel) < NUM_PART);

    // Table storage: cleared on reset, one entry written per trusted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PART; p++) begin
                for (int r = 0; r < NUM_REG; r++) begin
                    lo_mem[p][r]   <= '0;
                    hi_mem[p][r]   <= '0;
                    attr_mem[p][r] <= '0;
                end
            end
        end else if (wr_ok) begin
            lo_mem[cfg_part][cfg_idx]   <= cfg_lo;
            hi_mem[cfg_part][cfg_idx]   <= cfg_hi;
            attr_mem[cfg_part][cfg_idx] <= cfg_attr;
        end
    end

    // Active partition register and the reject pulse for untrusted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_part <= '0;
            cfg_reject  <= 1'b0;
        end else begin
            if (ld_ok) begin
                active_part <= part_sel;
            end
            cfg_reject <= (cfg_we || part_load) && !ctl_trusted;
        end
    end

    // Present the active partition's table to the matcher.
    for (genvar r = 0; r < NUM_REG; r++) begin : g_view
        assign act_lo[r]   = lo_mem[active_part][r];
        assign act_hi[r]   = hi_mem[active_part][r];
        assign act_attr[r] = attr_mem[active_part][r];
    end

endmodule

// File: rtl/mrg_region_match.sv
// Combinational range and permission check against one partition's table.
// One comparator pair per region; the grants of all hit regions are OR-ed.
// Assumes the table inputs are stable during the cycle.
module mrg_region_match
    import mem_region_guard_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_REG = 8
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [1:0]                     kind,
    input  logic [NUM_REG-1:0][ADDR_W-1:0] tab_lo,
    input  logic [NUM_REG-1:0][ADDR_W-1:0] tab_hi,
    input  logic [NUM_REG-1:0][ATTR_W-1:0] tab_attr,
    output logic                           granted
);

    logic [NUM_REG-1:0] hit;
    logic [NUM_REG-1:0] perm;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        region_attr_t a;
        assign a = region_attr_t'(tab_attr[r]);

        // Inclusive bounds; disabled regions never hit.
        assign hit[r] = a.en && (addr >= tab_lo[r]) && (addr <= tab_hi[r]);

        // Per-kind grant from this region's attributes.
        always_comb begin
            unique case (kind)
                KIND_FETCH: perm[r] = a.code;
                KIND_READ:  perm[r] = a.rd;
                KIND_WRITE: perm[r] = a.wr && !a.code;
                default:    perm[r] = 1'b0;
            endcase
        end
    end

    assign granted = |(hit & perm);

endmodule

// File: rtl/mrg_fault_log.sv
// Registers the outcome of each checked access: a one-cycle fault pulse
// and the address and kind of the most recent denied access.
// Assumes deny is meaningful only while valid is high.
module mrg_fault_log #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              deny,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    output logic              fault_o,
    output logic [ADDR_W-1:0] fault_addr,
    output logic [1:0]        fault_kind
);

    // Capture a denied access; otherwise drop the pulse and keep the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_o    <= 1'b0;
            fault_addr <= '0;
            fault_kind <= '0;
        end else begin
            fault_o <= valid && deny;
            if (valid && deny) begin
                fault_addr <= addr;
                fault_kind <= kind;
            end
        end
    end

endmodule

// File: rtl/mem_region_guard.sv
// Top of the partition memory region guard. It holds a region table for every
// partition, checks each access against the active one, lets trusted accesses
// through, and registers the details of each fault.
// Assumes access inputs are steady for the cycle in which acc_valid is high.
module mem_region_guard
    import mem_region_guard_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_PART = 4,
    parameter int NUM_REG  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctl_trusted,
    input  logic                        cfg_we,
    input  logic [$clog2(NUM_PART)-1:0] cfg_part,
    input  logic [$clog2(NUM_REG)-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0]           cfg_lo,
    input  logic [ADDR_W-1:0]           cfg_hi,
    input  logic [3:0]                  cfg_attr,
    input  logic                        part_load,
    input  logic [$clog2(NUM_PART)-1:0] part_sel,
    output logic [$clog2(NUM_PART)-1:0] active_part,
    output logic                        cfg_reject,
    input  logic                        acc_valid,
    input  logic                        acc_trusted,
    input  logic [1:0]                  acc_kind,
    input  logic [ADDR_W-1:0]           acc_addr,
    output logic                        acc_allow,
    output logic                        fault_o,
    output logic [ADDR_W-1:0]           fault_addr,
    output logic [1:0]                  fault_kind
);

    logic [NUM_REG-1:0][ADDR_W-1:0] tab_lo;
    logic [NUM_REG-1:0][ADDR_W-1:0] tab_hi;
    logic [NUM_REG-1:0][ATTR_W-1:0] tab_attr;
    logic                           granted;

    mrg_table_store #(
        .ADDR_W(ADDR_W), .NUM_PART(NUM_PART), .NUM_REG(NUM_REG)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .ctl_trusted(ctl_trusted),
        .cfg_we(cfg_we), .cfg_part(cfg_part), .cfg_idx(cfg_idx),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_attr(cfg_attr),
        .part_load(part_load), .part_sel(part_sel),
        .active_part(active_part), .cfg_reject(cfg_reject),
        .act_lo(tab_lo), .act_hi(tab_hi), .act_attr(tab_attr)
    );

    mrg_region_match #(
        .ADDR_W(ADDR_W), .NUM_REG(NUM_REG)
    ) u_match (
        .addr(acc_addr), .kind(acc_kind),
        .tab_lo(tab_lo), .tab_hi(tab_hi), .tab_attr(tab_attr),
        .granted(granted)
    );

    // Trusted accesses bypass the table; untrusted ones need a grant.
    assign acc_allow = acc_valid && (acc_trusted || granted);

    mrg_fault_log #(
        .ADDR_W(ADDR_W)
    ) u_log (
        .clk(clk), .rst_n(rst_n), .valid(acc_valid), .deny(!acc_allow),
        .addr(acc_addr), .kind(acc_kind),
        .fault_o(fault_o), .fault_addr(fault_addr), .fault_kind(fault_kind)
    );

endmodule

// File: rtl/mem_region_guard_chk.sv
// Property checker for mem_region_guard, attached through bind.
// Observes only top-level ports; assumes a synchronous active-low reset.
module mem_region_guard_chk #(
    parameter int ADDR_W   = 32,
    parameter int NUM_PART = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ctl_trusted,
    input logic                        cfg_we,
    input logic                        part_load,
    input logic [$clog2(NUM_PART)-1:0] active_part,
    input logic                        cfg_reject,
    input logic                        acc_valid,
    input logic                        acc_trusted,
    input logic [1:0]                  acc_kind,
    input logic [ADDR_W-1:0]           acc_addr,
    input logic                        acc_allow,
    input logic                        fault_o,
    input logic [ADDR_W-1:0]           fault_addr,
    input logic [1:0]                  fault_kind
);

    assert_trusted_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_trusted) |-> acc_allow);

    assert_reserved_denied_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_trusted && acc_kind == 2'd3) |-> !acc_allow);

    assert_fault_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=>
            (fault_o && fault_addr == $past(acc_addr) && fault_kind == $past(acc_kind)));

    assert_no_spurious_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_allow) |=> !fault_o);

    assert_reject_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we || part_load) && !ctl_trusted) |=> cfg_reject);

    assert_no_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((cfg_we || part_load) && !ctl_trusted) |=> !cfg_reject);

    assert_part_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(part_load && ctl_trusted) |=> $stable(active_part));

endmodule

bind mem_region_guard mem_region_guard_chk #(
    .ADDR_W(ADDR_W), .NUM_PART(NUM_PART)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_trusted(ctl_trusted), .cfg_we(cfg_we),
    .part_load(part_load), .active_part(active_part), .cfg_reject(cfg_reject),
    .acc_valid(acc_valid), .acc_trusted(acc_trusted), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_allow(acc_allow), .fault_o(fault_o),
    .fault_addr(fault_addr), .fault_kind(fault_kind)
);

// File: tb/mem_region_guard_test.sv
// Directed bench: one task per scenario, each checking its own results.
module mem_region_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_trusted = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_part = '0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_lo = '0;
    logic [31:0] cfg_hi = '0;
    logic [3:0]  cfg_attr = '0;
    logic        part_load = 1'b0;
    logic [1:0]  part_sel = '0;
    logic [1:0]  active_part;
    logic        cfg_reject;
    logic        acc_valid = 1'b0;
    logic        acc_trusted = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_allow;
    logic        fault_o;
    logic [31:0] fault_addr;
    logic [1:0]  fault_kind;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Attribute encodings: {wr, rd, code, en}
    localparam logic [3:0] A_RW   = 4'b1101;
    localparam logic [3:0] A_RO   = 4'b0101;
    localparam logic [3:0] A_WO   = 4'b1001;
    localparam logic [3:0] A_CODE = 4'b1111;
    localparam logic [3:0] A_OFF  = 4'b1100;

    mem_region_guard uut (
        .clk(clk), .rst_n(rst_n), .ctl_trusted(ctl_trusted), .cfg_we(cfg_we),
        .cfg_part(cfg_part), .cfg_idx(cfg_idx), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_attr(cfg_attr), .part_load(part_load), .part_sel(part_sel),
        .active_part(active_part), .cfg_reject(cfg_reject),
        .acc_valid(acc_valid), .acc_trusted(acc_trusted), .acc_kind(acc_kind),
        .acc_addr(acc_addr), .acc_allow(acc_allow), .fault_o(fault_o),
        .fault_addr(fault_addr), .fault_kind(fault_kind)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Write one region entry; the reject flag must match the privilege (R8).
    task automatic put_region(input logic [1:0] p, input logic [2:0] i,
                              input logic [31:0] lo, input logic [31:0] hi,
                              input logic [3:0] attr, input bit trusted);
        ctl_trusted = trusted; cfg_we = 1'b1; cfg_part = p; cfg_idx = i;
        cfg_lo = lo; cfg_hi = hi; cfg_attr = attr;
        step();
        cfg_we = 1'b0; ctl_trusted = 1'b0;
        check(cfg_reject == !trusted, "R8 reject flag after region write", cfg_reject, !trusted);
    endtask

    // Present one access, check allow at once and the fault record a cycle later (R10).
    task automatic probe(input logic [1:0] kind, input logic [31:0] addr,
                         input bit trusted, input bit exp_allow, input string req);
        acc_valid = 1'b1; acc_kind = kind; acc_addr = addr; acc_trusted = trusted;
        #1;
        check(acc_allow == exp_allow, req, acc_allow, exp_allow);
        step();
        acc_valid = 1'b0; acc_trusted = 1'b0;
        check(fault_o == !exp_allow, {req, " / R10 fault flag"}, fault_o, !exp_allow);
        if (!exp_allow) begin
            check(fault_addr == addr, {req, " / R10 fault address"}, fault_addr, addr);
            check(fault_kind == kind, {req, " / R10 fault kind"}, fault_kind, kind);
        end
        step();
        check(fault_o == 1'b0, "R10 flag clears after idle cycle", fault_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        check(fault_o == 1'b0, "R1 fault_o after reset", fault_o, 0);
        check(cfg_reject == 1'b0, "R1 cfg_reject after reset", cfg_reject, 0);
        check(active_part == 2'd0, "R1 active_part after reset", active_part, 0);
        probe(2'd1, 32'h0000_0100, 1'b0, 1'b0, "R1 R3 empty table denies");
    endtask

    task automatic t_bounds();
        put_region(2'd0, 3'd0, 32'h1000, 32'h1FFF, A_RW, 1'b1);
        probe(2'd1, 32'h1000, 1'b0, 1'b1, "R2 lower bound inside");
        probe(2'd1, 32'h1FFF, 1'b0, 1'b1, "R2 upper bound inside");
        probe(2'd1, 32'h0FFF, 1'b0, 1'b0, "R2 below lower bound");
        probe(2'd2, 32'h2000, 1'b0, 1'b0, "R2 above upper bound");
    endtask

    task automatic t_disable();
        put_region(2'd0, 3'd0, 32'h1000, 32'h1FFF, A_OFF, 1'b1);
        probe(2'd1, 32'h1500, 1'b0, 1'b0, "R3 disabled region never matches");
        put_region(2'd0, 3'd0, 32'h1000, 32'h1FFF, A_RW, 1'b1);
        probe(2'd1, 32'h1500, 1'b0, 1'b1, "R3 re-enabled region matches");
    endtask

    task automatic t_code();
        put_region(2'd0, 3'd1, 32'h4000, 32'h4FFF, A_CODE, 1'b1);
        probe(2'd0, 32'h4100, 1'b0, 1'b1, "R4 fetch from code region");
        probe(2'd0, 32'h1500, 1'b0, 1'b0, "R4 fetch from data region");
        probe(2'd1, 32'h4100, 1'b0, 1'b1, "R5 read of readable code region");
        probe(2'd2, 32'h4100, 1'b0, 1'b0, "R5 write to code region");
    endtask

    task automatic t_rw();
        put_region(2'd0, 3'd2, 32'h6000, 32'h60FF, A_RO, 1'b1);
        put_region(2'd0, 3'd3, 32'h7000, 32'h70FF, A_WO, 1'b1);
        probe(2'd1, 32'h6010, 1'b0, 1'b1, "R5 read of read-only region");
        probe(2'd2, 32'h6010, 1'b0, 1'b0, "R5 write to read-only region");
        probe(2'd2, 32'h7010, 1'b0, 1'b1, "R5 write to write-only region");
        probe(2'd1, 32'h7010, 1'b0, 1'b0, "R5 read of write-only region");
    endtask

    task automatic t_overlap();
        put_region(2'd0, 3'd4, 32'h6080, 32'h6FFF, A_WO, 1'b1);
        probe(2'd2, 32'h6090, 1'b0, 1'b1, "R6 overlap, one region grants");
        probe(2'd2, 32'h6050, 1'b0, 1'b0, "R6 only read-only region hit");
        probe(2'd1, 32'h6090, 1'b0, 1'b1, "R6 overlap read via other region");
    endtask

    task automatic t_reserved_and_trusted();
        probe(2'd3, 32'h1500, 1'b0, 1'b0, "R11 reserved kind denied");
        probe(2'd0, 32'hFFFF_0000, 1'b1, 1'b1, "R7 trusted fetch anywhere");
        probe(2'd3, 32'h0000_0004, 1'b1, 1'b1, "R7 trusted bypass of reserved kind");
    endtask

    task automatic t_untrusted_cfg();
        put_region(2'd0, 3'd5, 32'h8000, 32'h80FF, A_RW, 1'b0);
        step();
        check(cfg_reject == 1'b0, "R8 reject is a single pulse", cfg_reject, 0);
        probe(2'd1, 32'h8000, 1'b0, 1'b0, "R8 untrusted write left table unchanged");
        ctl_trusted = 1'b0; part_load = 1'b1; part_sel = 2'd1;
        step();
        part_load = 1'b0;
        check(cfg_reject == 1'b1, "R8 reject after untrusted load", cfg_reject, 1);
        check(active_part == 2'd0, "R8 untrusted load ignored", active_part, 0);
    endtask

    task automatic t_partition();
        put_region(2'd1, 3'd0, 32'h9000, 32'h90FF, A_RW, 1'b1);
        probe(2'd1, 32'h9000, 1'b0, 1'b0, "R9 other partition's region inactive");
        ctl_trusted = 1'b1; part_load = 1'b1; part_sel = 2'd1;
        step();
        part_load = 1'b0; ctl_trusted = 1'b0;
        check(active_part == 2'd1, "R9 trusted load switches partition", active_part, 1);
        check(cfg_reject == 1'b0, "R8 no reject on trusted load", cfg_reject, 0);
        probe(2'd1, 32'h9000, 1'b0, 1'b1, "R9 new partition's region applies");
        probe(2'd1, 32'h1500, 1'b0, 1'b0, "R9 previous partition's region gone");
    endtask

    initial begin
        t_reset();
        t_bounds();
        t_disable();
        t_code();
        t_rw();
        t_overlap();
        t_reserved_and_trusted();
        t_untrusted_cfg();
        t_partition();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule